// File: doc/BRIEF.md
# Split-Row Threshold MinSum Check Node

This block computes the check-to-variable messages for one parity-check row of a MinSum LDPC decoder. The row's variable-to-check messages are split into equal, contiguous partitions. Each partition finds its own smallest and second-smallest magnitudes. Partitions do not exchange minimum values. Between partitions there is only one flag bit per partition and one sign-parity bit per partition. A partition raises its flag when its local minimum is below a programmable threshold. When any other partition has its flag raised, each local magnitude that lies above the threshold is clipped down to the threshold.

A whole row enters in one cycle as sign bits plus a packed magnitude vector. The decoder's iteration logic drives `in_valid` once per row, and may do so every cycle. The results appear on the outputs one clock later together with `out_valid`. When no row is presented, the outputs keep their last values. Magnitudes and the threshold are 5-bit unsigned fixed-point values with 3 fractional bits. A code of 2 therefore stands for 0.25.

Top module: `srt_check_node`

## Requirements
- R1: While reset is asserted and until the first accepted row, `out_valid`, `out_sign` and `out_mag` are all zero.
- R2: A row sampled with `in_valid` high at a rising edge produces its results and `out_valid` high after that edge. `out_valid` is low after any edge at which `in_valid` was low. Rows may arrive on consecutive cycles.
- R3: After an edge at which `in_valid` is low, `out_sign` and `out_mag` keep their previous values.
- R4: Position i belongs to partition i / (ROW_W/PARTS). Its magnitude occupies bits [5i+4:5i] of `in_mag` and `out_mag`, and its sign is bit i. Without replacement, the position holding the partition's smallest magnitude receives the second-smallest magnitude, and every other position of that partition receives the smallest.
- R5: When several positions share a partition's smallest magnitude, the lowest-indexed one counts as the minimum position, and the second-smallest equals that same value.
- R6: A partition's flag is set exactly when its local minimum is strictly less than `thresh`.
- R7: If at least one other partition has its flag set, the partition's minimum and second-minimum are each replaced by `thresh` when they are strictly greater than `thresh`. Each of the two is judged separately.
- R8: A partition's own flag never causes replacement in that same partition.
- R9: Each output sign is the XOR of the signs of all other positions in the whole row.
- R10: A local minimum equal to `thresh` neither sets the flag nor is replaced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A row is presented this cycle |
| in_sign | input | ROW_W | Input sign bits, 1 = negative |
| in_mag | input | ROW_W*5 | Packed input magnitudes, Q2.3 unsigned |
| thresh | input | 5 | Threshold, same format as the magnitudes |
| out_valid | output | 1 | Results for the previously accepted row |
| out_sign | output | ROW_W | Output sign bits |
| out_mag | output | ROW_W*5 | Packed output magnitudes |

## Verification
The bench uses several row patterns, and each one separates different failure modes.

- **No partition below threshold.** This shows that the basic split minimum and second-minimum placement works without replacement.
- **One partition below threshold.** This shows clipping in the other partitions while the flagged partition keeps its own value.
- **Boundary row.** Here one local minimum equals the threshold, and in another partition only the second minimum lies above it. This row separates strict from non-strict comparisons and shows that the two minima are clipped independently.
- **Duplicated minima and mixed sign patterns.** These expose tie handling and parity that skips the position's own sign.
- **Back-to-back rows followed by idle cycles.** These show the latency and that the outputs hold when no row is presented.

// File: rtl/srt_pkg.sv
package srt_pkg;

    // Fixed message format: unsigned magnitude, 3 fractional bits.
    localparam int MAG_W = 5;

    typedef logic [MAG_W-1:0] mag_t;

    typedef struct packed {
        mag_t min1;   // smallest local magnitude
        mag_t min2;   // second smallest local magnitude
        logic flag;   // local minimum strictly below threshold
        logic sx;     // XOR of local signs
    } part_stat_t;

    // Clip a value to the threshold when another partition is below it.
    function automatic mag_t clip_mag(mag_t v, mag_t t, logic other_low);
        return (other_low && (v > t)) ? t : v;
    endfunction

endpackage

// File: rtl/srt_part_scan.sv
module srt_part_scan
    import srt_pkg::*;
#(
    parameter int PART_SIZE = 8
) (
    input  logic [PART_SIZE-1:0]       sgn,
    input  logic [PART_SIZE*MAG_W-1:0] mag,
    input  mag_t                       thresh,
    output part_stat_t                 stat,
    output logic [$clog2(PART_SIZE)-1:0] min_idx
);

    localparam int IDX_W = $clog2(PART_SIZE);

    mag_t             lo;
    mag_t             nx;
    mag_t             v;
    logic [IDX_W-1:0] at;

    always_comb begin
        lo = '1;
        nx = '1;
        at = '0;
        v  = '0;
        for (int k = 0; k < PART_SIZE; k++) begin
            v = mag[k*MAG_W +: MAG_W];
            if (v < lo) begin
                nx = lo;
                lo = v;
                at = IDX_W'(k);
            end else if (v < nx) begin
                nx = v;
            end
        end
        stat.min1 = lo;
        stat.min2 = nx;
        stat.flag = (lo < thresh);
        stat.sx   = ^sgn;
        min_idx   = at;
    end

endmodule

// File: rtl/srt_part_out.sv
module srt_part_out
    import srt_pkg::*;
#(
    parameter int PART_SIZE = 8
) (
    input  part_stat_t                   stat,
    input  logic [$clog2(PART_SIZE)-1:0] min_idx,
    input  mag_t                         thresh,
    input  logic                         other_low,
    input  logic                         row_sx,
    input  logic [PART_SIZE-1:0]         sgn,
    output logic [PART_SIZE-1:0]         o_sgn,
    output logic [PART_SIZE*MAG_W-1:0]   o_mag
);

    localparam int IDX_W = $clog2(PART_SIZE);

    mag_t sel1;
    mag_t sel2;

    assign sel1 = clip_mag(stat.min1, thresh, other_low);
    assign sel2 = clip_mag(stat.min2, thresh, other_low);

    for (genvar k = 0; k < PART_SIZE; k++) begin : g_pos
        assign o_mag[k*MAG_W +: MAG_W] = (min_idx == IDX_W'(k)) ? sel2 : sel1;
        assign o_sgn[k] = row_sx ^ sgn[k];
    end

endmodule

// File: rtl/srt_check_node.sv
module srt_check_node
    import srt_pkg::*;
#(
    parameter int ROW_W = 32,
    parameter int PARTS = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic [ROW_W-1:0]       in_sign,
    input  logic [ROW_W*MAG_W-1:0] in_mag,
    input  logic [MAG_W-1:0]       thresh,
    output logic                   out_valid,
    output logic [ROW_W-1:0]       out_sign,
    output logic [ROW_W*MAG_W-1:0] out_mag
);

    localparam int PART_SIZE = ROW_W / PARTS;
    localparam int IDX_W     = $clog2(PART_SIZE);
    localparam int PSEG      = PART_SIZE * MAG_W;

    typedef struct packed {
        logic                   valid;
        logic [ROW_W-1:0]       sgn;
        logic [ROW_W*MAG_W-1:0] mag;
    } out_state_t;

    part_stat_t             stat_w [PARTS];
    logic [IDX_W-1:0]       idx_w  [PARTS];
    logic [PARTS-1:0]       flag_w;
    logic [PARTS-1:0]       sx_w;
    logic                   row_sx;
    logic [ROW_W-1:0]       nxt_sgn;
    logic [ROW_W*MAG_W-1:0] nxt_mag;

    out_state_t state_d;
    out_state_t state_q;

    // Per-partition scan: local minima, flag and sign parity.
    for (genvar p = 0; p < PARTS; p++) begin : g_scan
        srt_part_scan #(.PART_SIZE(PART_SIZE)) u_scan (
            .sgn     (in_sign[p*PART_SIZE +: PART_SIZE]),
            .mag     (in_mag[p*PSEG +: PSEG]),
            .thresh  (thresh),
            .stat    (stat_w[p]),
            .min_idx (idx_w[p])
        );
        assign flag_w[p] = stat_w[p].flag;
        assign sx_w[p]   = stat_w[p].sx;
    end

    assign row_sx = ^sx_w;

    // Per-partition output: only the other partitions' flags are seen.
    for (genvar p = 0; p < PARTS; p++) begin : g_out
        logic [PARTS-1:0] others;
        assign others = flag_w & ~(PARTS'(1) << p);

        srt_part_out #(.PART_SIZE(PART_SIZE)) u_out (
            .stat      (stat_w[p]),
            .min_idx   (idx_w[p]),
            .thresh    (thresh),
            .other_low (|others),
            .row_sx    (row_sx),
            .sgn       (in_sign[p*PART_SIZE +: PART_SIZE]),
            .o_sgn     (nxt_sgn[p*PART_SIZE +: PART_SIZE]),
            .o_mag     (nxt_mag[p*PSEG +: PSEG])
        );
    end

    always_comb begin
        state_d       = state_q;
        state_d.valid = in_valid;
        if (in_valid) begin
            state_d.sgn = nxt_sgn;
            state_d.mag = nxt_mag;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign out_valid = state_q.valid;
    assign out_sign  = state_q.sgn;
    assign out_mag   = state_q.mag;

endmodule

// File: rtl/srt_check_node_chk.sv
module srt_check_node_chk
    import srt_pkg::*;
#(
    parameter int ROW_W = 32,
    parameter int PARTS = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   in_valid,
    input logic [ROW_W-1:0]       in_sign,
    input logic [ROW_W*MAG_W-1:0] in_mag,
    input logic [MAG_W-1:0]       thresh,
    input logic                   out_valid,
    input logic [ROW_W-1:0]       out_sign,
    input logic [ROW_W*MAG_W-1:0] out_mag
);

    localparam int PART_SIZE = ROW_W / PARTS;

    mag_t in_max;
    logic in_par;

    always_comb begin
        in_max = '0;
        for (int i = 0; i < ROW_W; i++) begin
            if (in_mag[i*MAG_W +: MAG_W] > in_max) in_max = in_mag[i*MAG_W +: MAG_W];
        end
        in_par = ^in_sign;
    end

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2
    valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R3
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_sign) && $stable(out_mag)));

    // R9
    sign_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ((^out_sign) == ((ROW_W % 2 == 0) ? $past(in_par) : 1'b0)));

    // R7
    mag_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_mag[MAG_W-1:0] <= $past(in_max)));

    for (genvar p = 0; p < PARTS; p++) begin : g_part
        mag_t lo;
        int   above;
        always_comb begin
            lo = '1;
            for (int k = 0; k < PART_SIZE; k++) begin
                if (out_mag[(p*PART_SIZE+k)*MAG_W +: MAG_W] < lo)
                    lo = out_mag[(p*PART_SIZE+k)*MAG_W +: MAG_W];
            end
            above = 0;
            for (int k = 0; k < PART_SIZE; k++) begin
                if (out_mag[(p*PART_SIZE+k)*MAG_W +: MAG_W] > lo) above++;
            end
        end

        // R4
        part_spread_chk: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> (above <= 1));
    end

endmodule

bind srt_check_node srt_check_node_chk #(.ROW_W(ROW_W), .PARTS(PARTS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_sign   (in_sign),
    .in_mag    (in_mag),
    .thresh    (thresh),
    .out_valid (out_valid),
    .out_sign  (out_sign),
    .out_mag   (out_mag)
);

// File: tb/srt_check_node_tb.sv
module srt_check_node_tb;

    localparam int ROW_W = 32;
    localparam int PARTS = 4;
    localparam int MW    = 5;
    localparam int PS    = ROW_W / PARTS;
    localparam int VW    = ROW_W * MW;

    logic          clk = 0;
    logic          rst_n = 0;
    logic          in_valid = 0;
    logic [ROW_W-1:0] in_sign = '0;
    logic [VW-1:0] in_mag = '0;
    logic [MW-1:0] thresh = '0;
    logic          out_valid;
    logic [ROW_W-1:0] out_sign;
    logic [VW-1:0] out_mag;

    int n_chk = 0;
    int n_fail = 0;

    logic [ROW_W-1:0] e_sgn;
    logic [VW-1:0]    e_mag;

    always #5 clk = ~clk;

    srt_check_node #(.ROW_W(ROW_W), .PARTS(PARTS)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sign(in_sign),
        .in_mag(in_mag), .thresh(thresh), .out_valid(out_valid),
        .out_sign(out_sign), .out_mag(out_mag)
    );

    task automatic chk(input string tag, input logic [VW-1:0] act, input logic [VW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [MW-1:0] mag_at(input logic [VW-1:0] v, input int i);
        return v[i*MW +: MW];
    endfunction

    // Behavioural model of the split threshold rule.
    task automatic model(input logic [ROW_W-1:0] s, input logic [VW-1:0] m, input logic [MW-1:0] t);
        int m1 [PARTS];
        int m2 [PARTS];
        int ix [PARTS];
        bit fl [PARTS];
        bit par;
        par = ^s;
        for (int p = 0; p < PARTS; p++) begin
            m1[p] = 99; m2[p] = 99; ix[p] = 0;
            for (int k = 0; k < PS; k++) begin
                int v;
                v = int'(mag_at(m, p*PS+k));
                if (v < m1[p]) begin m2[p] = m1[p]; m1[p] = v; ix[p] = k; end
                else if (v < m2[p]) m2[p] = v;
            end
            fl[p] = (m1[p] < int'(t));
        end
        for (int p = 0; p < PARTS; p++) begin
            bit oth;
            int a;
            int b;
            oth = 0;
            for (int q = 0; q < PARTS; q++) if (q != p && fl[q]) oth = 1;
            a = (oth && m1[p] > int'(t)) ? int'(t) : m1[p];
            b = (oth && m2[p] > int'(t)) ? int'(t) : m2[p];
            for (int k = 0; k < PS; k++) begin
                e_mag[(p*PS+k)*MW +: MW] = MW'((k == ix[p]) ? b : a);
                e_sgn[p*PS+k] = par ^ s[p*PS+k];
            end
        end
    endtask

    // Present one row and wait until its result is on the outputs.
    task automatic send(input logic [ROW_W-1:0] s, input logic [VW-1:0] m, input logic [MW-1:0] t);
        @(negedge clk);
        in_valid = 1; in_sign = s; in_mag = m; thresh = t;
        @(negedge clk);
        in_valid = 0;
        model(s, m, t);
    endtask

    function automatic logic [VW-1:0] base_row(input int off);
        logic [VW-1:0] r;
        for (int i = 0; i < ROW_W; i++) r[i*MW +: MW] = MW'(((i * 7 + off) % 20) + 8);
        return r;
    endfunction

    task automatic t_reset();
        chk("R1 valid", VW'(out_valid), '0);
        chk("R1 sign", VW'(out_sign), '0);
        chk("R1 mag", out_mag, '0);
    endtask

    task automatic t_plain();
        logic [VW-1:0] m;
        m = base_row(3);
        m[5*MW +: MW] = 4; m[2*MW +: MW] = 6;   // partition 0: min 4 at 5, second 6
        send('0, m, 2);
        chk("R2 valid", VW'(out_valid), VW'(1));
        chk("R4 row", out_mag, e_mag);
        chk("R4 min pos", VW'(mag_at(out_mag, 5)), VW'(6));
        chk("R4 other pos", VW'(mag_at(out_mag, 0)), VW'(4));
        chk("R6 no flag keeps", VW'(mag_at(out_mag, 12)), VW'(mag_at(e_mag, 12)));
    endtask

    task automatic t_replace();
        logic [VW-1:0] m;
        m = base_row(1);
        m[10*MW +: MW] = 1; m[13*MW +: MW] = 5;  // partition 1 flagged
        send('0, m, 2);
        chk("R7 row", out_mag, e_mag);
        chk("R7 clipped p0", VW'(mag_at(out_mag, 0)), VW'(2));
        chk("R7 clipped p3", VW'(mag_at(out_mag, 30)), VW'(2));
        chk("R8 own min kept", VW'(mag_at(out_mag, 11)), VW'(1));
        chk("R8 own second kept", VW'(mag_at(out_mag, 10)), VW'(5));
    endtask

    task automatic t_boundary();
        logic [VW-1:0] m;
        m = base_row(5);
        m[3*MW +: MW]  = 2;                       // p0 min equals thresh
        m[20*MW +: MW] = 0;                       // p2 flagged
        m[27*MW +: MW] = 1; m[29*MW +: MW] = 6;   // p3 min below, second above
        send('0, m, 2);
        chk("R10 row", out_mag, e_mag);
        chk("R10 equal kept", VW'(mag_at(out_mag, 1)), VW'(2));
        chk("R7 second clipped", VW'(mag_at(out_mag, 27)), VW'(2));
        chk("R7 first kept", VW'(mag_at(out_mag, 25)), VW'(1));
        chk("R6 p1 clipped by p2/p3", VW'(mag_at(out_mag, 9)), VW'(2));
    endtask

    task automatic t_ties();
        logic [VW-1:0] m;
        m = base_row(7);
        m[17*MW +: MW] = 3; m[19*MW +: MW] = 3;
        send('0, m, 1);
        chk("R5 row", out_mag, e_mag);
        chk("R5 first tie", VW'(mag_at(out_mag, 17)), VW'(3));
        chk("R5 second tie", VW'(mag_at(out_mag, 19)), VW'(3));
        chk("R5 rest", VW'(mag_at(out_mag, 22 - 6)), VW'(3));
    endtask

    task automatic t_signs();
        logic [ROW_W-1:0] s;
        s = 32'hA5_3C_00_81;
        send(s, base_row(2), 2);
        chk("R9 row", VW'(out_sign), VW'(e_sgn));
        chk("R9 pos0", VW'(out_sign[0]), VW'((^s) ^ s[0]));
        s = 32'h0000_0010;
        send(s, base_row(2), 2);
        chk("R9 single neg self", VW'(out_sign[4]), VW'(0));
        chk("R9 single neg other", VW'(out_sign[9]), VW'(1));
    endtask

    task automatic t_stream();
        logic [VW-1:0] held;
        logic [ROW_W-1:0] hs;
        logic [VW-1:0] ma;
        logic [VW-1:0] mb;
        ma = base_row(4); ma[8*MW +: MW] = 0;
        mb = base_row(9);
        @(negedge clk);
        in_valid = 1; in_sign = 32'h1; in_mag = ma; thresh = 3;
        @(negedge clk);
        model(32'h1, ma, 3);
        chk("R2 stream a", out_mag, e_mag);
        in_sign = 32'h6; in_mag = mb; thresh = 3;
        @(negedge clk);
        model(32'h6, mb, 3);
        chk("R2 stream b", out_mag, e_mag);
        chk("R2 stream b sign", VW'(out_sign), VW'(e_sgn));
        in_valid = 0; in_mag = base_row(0); in_sign = '1;
        held = out_mag; hs = out_sign;
        @(negedge clk);
        chk("R2 idle valid", VW'(out_valid), '0);
        chk("R3 hold mag", out_mag, held);
        @(negedge clk);
        chk("R3 hold sign", VW'(out_sign), VW'(hs));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_plain();
        t_replace();
        t_boundary();
        t_ties();
        t_signs();
        t_stream();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule